// File: doc/BRIEF.md
# Four-Phase Asynchronous Bus Handshake Link

This block joins a bus master and a bus slave that run on two unrelated clocks. No clock is shared, so they coordinate only through two level signals: a request from the master and an acknowledge from the slave. Each side moves forward only after it has seen the other side's level change. Every transfer passes through four edges in order: request rises, acknowledge rises, request falls, acknowledge falls.

Local logic on the master side starts a transfer by pulsing a start input while the link reports ready. The start carries an address, write data and a direction bit. The master first places the address, data and direction on the bus. It raises request only after that. It keeps all bus fields steady until it sees acknowledge low again.

The slave brings request into its own clock domain through a two-flop synchronizer. It captures the bus fields and shows them to its local logic for one cycle. For a read, it takes the local logic's read data in that same cycle and drives it on the bus before it raises acknowledge. The master samples the read data when its synchronized copy of acknowledge is high. It reports completion once it has seen acknowledge return low.

Top module: `async_bus_link`

## Requirements
- R1: While reset is held and in the first cycles after it, `m_ready` is 1, `m_done` is 0 and `s_valid` is 0.
- R2: After a start is accepted, the master drives address, write data and direction on the bus one master cycle before it raises request. Those bus fields stay unchanged until the master has seen acknowledge low.
- R3: For each accepted start, `s_valid` is high for exactly one slave cycle. In that cycle `s_addr`, `s_wdata` and `s_write` equal the values given at the start (`s_write`/`m_write` = 1 means write, 0 means read). No other `s_valid` pulse occurs.
- R4: The slave raises acknowledge only after the cycle in which it showed the captured transfer. It lowers acknowledge only after its synchronized request is low.
- R5: The master lowers request only after its synchronized acknowledge is high. `m_done` pulses for one master cycle only after acknowledge is seen low, and only after the slave has shown the transfer.
- R6: For a read, the slave samples `s_rdata` in its `s_valid` cycle and holds it on the bus while acknowledge is high. At `m_done`, `m_rdata` equals that value.
- R7: `m_ready` falls in the master cycle after a start is accepted and rises together with `m_done`. A start pulsed while `m_ready` is low is ignored. It causes no slave transfer and no change to the slave's stored data.
- R8: Transfers complete correctly whether the slave clock is slower or faster than the master clock. Accept to `m_done` takes at least 5 master cycles, because each handshake edge crosses a two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m | input | 1 | Master-side clock |
| rst_m_n | input | 1 | Master-side active-low reset |
| m_start | input | 1 | Start a transfer (taken only when m_ready is 1) |
| m_write | input | 1 | Direction: 1 write, 0 read |
| m_addr | input | ADDR_W | Transfer address |
| m_wdata | input | DATA_W | Write data |
| m_ready | output | 1 | Master idle, able to accept a start |
| m_done | output | 1 | One-cycle pulse when the handshake has completed |
| m_rdata | output | DATA_W | Read data returned, valid at m_done |
| clk_s | input | 1 | Slave-side clock |
| rst_s_n | input | 1 | Slave-side active-low reset |
| s_valid | output | 1 | One-cycle pulse presenting a captured transfer |
| s_write | output | 1 | Captured direction |
| s_addr | output | ADDR_W | Captured address |
| s_wdata | output | DATA_W | Captured write data |
| s_rdata | input | DATA_W | Read data from slave local logic, sampled in the s_valid cycle |

## Verification
Some internal faults show up within a transfer or two. A master that drops request too early, or a slave that releases acknowledge while request is still high, shows up at the ports as a duplicated or missing `s_valid` pulse. It can also show up as `m_done` arriving before the slave has presented the transfer. A broken bus hold, or read data sampled at the wrong moment, appears as wrong captured fields or a wrong `m_rdata` at `m_done`. A state machine stuck busy, or one that accepts a start while busy, breaks the ready tracking that is compared on every master cycle. It also leaves a trace in the data read back afterwards.

// File: rtl/abl_pkg.sv
`timescale 1ns/1ps
package abl_pkg;
    typedef enum logic [1:0] {
        M_IDLE    = 2'd0,
        M_SETUP   = 2'd1,
        M_REQ     = 2'd2,
        M_RELEASE = 2'd3
    } mst_state_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SERVE = 2'd1,
        S_HOLD  = 2'd2
    } slv_state_e;
endpackage

// File: rtl/abl_sync.sv
`timescale 1ns/1ps
module abl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/abl_master.sv
`timescale 1ns/1ps
module abl_master
    import abl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              write_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              ready_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    output logic              bus_write_o,
    output logic              bus_req_o,
    input  logic [DATA_W-1:0] bus_rdata_i,
    input  logic              ack_sync_i
);
    typedef struct packed {
        mst_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              write;
        logic              req;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } mst_regs_t;

    mst_regs_t d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.state)
            M_IDLE: begin
                if (start_i) begin
                    d.addr  = addr_i;
                    d.wdata = wdata_i;
                    d.write = write_i;
                    d.state = M_SETUP;
                end
            end
            M_SETUP: begin
                d.req   = 1'b1;
                d.state = M_REQ;
            end
            M_REQ: begin
                if (ack_sync_i) begin
                    d.req   = 1'b0;
                    d.rdata = bus_rdata_i;
                    d.state = M_RELEASE;
                end
            end
            M_RELEASE: begin
                if (!ack_sync_i) begin
                    d.done  = 1'b1;
                    d.state = M_IDLE;
                end
            end
            default: d.state = M_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ready_o     = (q.state == M_IDLE);
    assign done_o      = q.done;
    assign rdata_o     = q.rdata;
    assign bus_addr_o  = q.addr;
    assign bus_wdata_o = q.wdata;
    assign bus_write_o = q.write;
    assign bus_req_o   = q.req;

    assert_bus_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == M_REQ || q.state == M_RELEASE) |->
            ($stable(q.addr) && $stable(q.wdata) && $stable(q.write)));

    assert_req_after_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.req) |-> $past(q.state) == M_SETUP);

    assert_req_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.req) |-> $past(ack_sync_i));

    assert_done_after_ack_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (!$past(ack_sync_i) && !q.req));

    assert_no_accept_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state != M_IDLE) |=> (q.state != M_SETUP));
endmodule

// File: rtl/abl_slave.sv
`timescale 1ns/1ps
module abl_slave
    import abl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_sync_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic              bus_write_i,
    output logic              bus_ack_o,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              valid_o,
    output logic              write_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    input  logic [DATA_W-1:0] rdata_i
);
    typedef struct packed {
        slv_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              write;
        logic [DATA_W-1:0] rdata;
        logic              ack;
        logic              valid;
    } slv_regs_t;

    slv_regs_t d, q;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        case (q.state)
            S_IDLE: begin
                if (req_sync_i) begin
                    d.addr  = bus_addr_i;
                    d.wdata = bus_wdata_i;
                    d.write = bus_write_i;
                    d.valid = 1'b1;
                    d.state = S_SERVE;
                end
            end
            S_SERVE: begin
                if (!q.write) d.rdata = rdata_i;
                d.ack   = 1'b1;
                d.state = S_HOLD;
            end
            S_HOLD: begin
                if (!req_sync_i) begin
                    d.ack   = 1'b0;
                    d.state = S_IDLE;
                end
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_ack_o   = q.ack;
    assign bus_rdata_o = q.rdata;
    assign valid_o     = q.valid;
    assign write_o     = q.write;
    assign addr_o      = q.addr;
    assign wdata_o     = q.wdata;

    assert_valid_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid |=> !q.valid);

    assert_ack_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ack) |-> $past(q.valid));

    assert_ack_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.ack) |-> !$past(req_sync_i));

    assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ack && $past(q.ack)) |-> $stable(q.rdata));
endmodule

// File: rtl/async_bus_link.sv
`timescale 1ns/1ps
module async_bus_link #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_m,
    input  logic              rst_m_n,
    input  logic              m_start,
    input  logic              m_write,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic [DATA_W-1:0] m_wdata,
    output logic              m_ready,
    output logic              m_done,
    output logic [DATA_W-1:0] m_rdata,
    input  logic              clk_s,
    input  logic              rst_s_n,
    output logic              s_valid,
    output logic              s_write,
    output logic [ADDR_W-1:0] s_addr,
    output logic [DATA_W-1:0] s_wdata,
    input  logic [DATA_W-1:0] s_rdata
);
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata;
    logic [DATA_W-1:0] bus_rdata;
    logic              bus_write;
    logic              bus_req;
    logic              bus_ack;
    logic              req_in_s;
    logic              ack_in_m;

    abl_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(clk_s), .rst_n(rst_s_n), .d_i(bus_req), .q_o(req_in_s)
    );

    abl_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(clk_m), .rst_n(rst_m_n), .d_i(bus_ack), .q_o(ack_in_m)
    );

    abl_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_master (
        .clk(clk_m), .rst_n(rst_m_n),
        .start_i(m_start), .write_i(m_write), .addr_i(m_addr), .wdata_i(m_wdata),
        .ready_o(m_ready), .done_o(m_done), .rdata_o(m_rdata),
        .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_write_o(bus_write),
        .bus_req_o(bus_req), .bus_rdata_i(bus_rdata), .ack_sync_i(ack_in_m)
    );

    abl_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slave (
        .clk(clk_s), .rst_n(rst_s_n), .req_sync_i(req_in_s),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_write_i(bus_write),
        .bus_ack_o(bus_ack), .bus_rdata_o(bus_rdata),
        .valid_o(s_valid), .write_o(s_write), .addr_o(s_addr), .wdata_o(s_wdata),
        .rdata_i(s_rdata)
    );
endmodule

// File: tb/sim_async_bus_link.sv
`timescale 1ns/1ps
module sim_async_bus_link;
    localparam int AW = 8;
    localparam int DW = 16;

    logic clk_m = 0, clk_s = 0, rst_m_n = 0, rst_s_n = 0;
    logic m_start = 0, m_write = 0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_wdata = '0;
    logic m_ready, m_done, s_valid, s_write;
    logic [DW-1:0] m_rdata, s_wdata, s_rdata;
    logic [AW-1:0] s_addr;

    integer half_s = 17;
    integer errors = 0, checks = 0;
    bit finished = 0;
    bit mon_on = 0;

    logic [DW-1:0] slv_mem   [256];
    logic [DW-1:0] model_mem [256];

    bit            busy = 0;
    bit            pend = 0;
    logic [AW-1:0] pend_addr;
    logic [DW-1:0] pend_data;
    logic          pend_wr;
    integer        xfers_seen = 0;

    always #10 clk_m = ~clk_m;
    initial forever #(half_s) clk_s = ~clk_s;

    async_bus_link u0 (
        .clk_m(clk_m), .rst_m_n(rst_m_n), .m_start(m_start), .m_write(m_write),
        .m_addr(m_addr), .m_wdata(m_wdata), .m_ready(m_ready), .m_done(m_done),
        .m_rdata(m_rdata), .clk_s(clk_s), .rst_s_n(rst_s_n), .s_valid(s_valid),
        .s_write(s_write), .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata)
    );

    assign s_rdata = slv_mem[s_addr];

    always @(posedge clk_s) if (s_valid && s_write) slv_mem[s_addr] <= s_wdata;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk_s) begin
        if (mon_on && s_valid) begin
            xfers_seen++;
            check(pend, "R3 unexpected s_valid", 1, 0);
            if (pend) begin
                check(s_addr == pend_addr, "R3 addr", s_addr, pend_addr);
                check(s_wdata == pend_data, "R3 wdata", s_wdata, pend_data);
                check(s_write == pend_wr, "R3 dir", s_write, pend_wr);
            end
            pend = 0;
        end
    end

    always @(negedge clk_m) begin
        if (mon_on) begin
            if (m_done) begin
                check(busy, "R5 done while idle", 0, 1);
                busy = 0;
            end
            check(m_ready == !busy, "R7 ready", m_ready, !busy);
            if (m_start && !busy) busy = 1;
        end
    end

    task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] dat,
                        input bit ghost);
        logic [DW-1:0] exp_rd;
        integer lat;
        integer seen_before;
        exp_rd = model_mem[a];
        if (wr) model_mem[a] = dat;
        seen_before = xfers_seen;
        pend_addr = a; pend_data = dat; pend_wr = wr; pend = 1;
        @(posedge clk_m); #2;
        m_start = 1; m_write = wr; m_addr = a; m_wdata = dat;
        @(posedge clk_m); #2;
        m_start = 0; m_addr = ~a; m_wdata = ~dat; m_write = ~wr;
        lat = 1;
        if (ghost) begin
            @(posedge clk_m); #2;
            m_start = 1; m_write = 1; m_addr = a; m_wdata = dat ^ 16'h5A5A;
            @(posedge clk_m); #2;
            m_start = 0;
            lat += 2;
        end
        while (!m_done && lat < 4000) begin
            @(negedge clk_m);
            if (!m_done) lat++;
        end
        check(lat < 4000, "R5 transfer timeout", lat, 0);
        check(lat >= 5, "R8 min latency", lat, 5);
        check(xfers_seen == seen_before + 1, "R5 slave shown before done", xfers_seen, seen_before + 1);
        if (!wr) check(m_rdata == exp_rd, "R6 read data", m_rdata, exp_rd);
        @(negedge clk_m);
    endtask

    initial begin
        #3000000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            slv_mem[i]   = DW'(i * 37 + 5);
            model_mem[i] = DW'(i * 37 + 5);
        end
        repeat (3) @(negedge clk_m);
        check(m_ready == 1, "R1 ready in reset", m_ready, 1);
        check(m_done == 0, "R1 done in reset", m_done, 0);
        check(s_valid == 0, "R1 valid in reset", s_valid, 0);
        rst_m_n = 1; rst_s_n = 1;
        repeat (4) @(negedge clk_m);
        check(m_ready == 1, "R1 ready after reset", m_ready, 1);
        check(s_valid == 0, "R1 valid after reset", s_valid, 0);
        mon_on = 1;

        // R8 slave slower than master
        xfer(1, 8'h10, 16'hBEEF, 0);
        xfer(0, 8'h10, 0, 0);
        xfer(0, 8'h22, 0, 0);
        xfer(1, 8'hFF, 16'hFFFF, 0);
        xfer(1, 8'h00, 16'h0000, 0);
        xfer(0, 8'hFF, 0, 0);
        xfer(0, 8'h00, 0, 0);

        // R8 slave faster than master
        half_s = 4;
        repeat (5) @(negedge clk_m);
        for (int k = 0; k < 6; k++) begin
            xfer(1, AW'(8'h40 + k), DW'(16'h1230 + k * 7), 0);
            xfer(0, AW'(8'h40 + k), 0, 0);
        end
        xfer(0, 8'h7E, 0, 0);

        // R7 start while busy is ignored
        xfer(1, 8'h30, 16'h1111, 1);
        xfer(0, 8'h30, 0, 0);

        // R8 much slower slave
        half_s = 47;
        repeat (5) @(negedge clk_m);
        xfer(1, 8'h55, 16'hA5A5, 1);
        xfer(0, 8'h55, 0, 0);
        xfer(0, 8'h81, 0, 0);
        xfer(1, 8'h81, 16'h0F0F, 0);
        xfer(0, 8'h81, 0, 0);

        repeat (20) @(negedge clk_m);
        check(!pend, "R3 transfer left unserved", pend, 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule